// File: doc/BRIEF.md
# Timed-Unlock Sleep Control Register

This block is an 8-bit control register with one protected bit. That bit asks the sleep controller to switch off the brown-out detector during the next sleep entry. Software sets it with a two-write unlock. The first write opens a short window. The second write, made inside that window, sets the bit. Once set, the bit waits a fixed delay and then counts as active for a fixed number of cycles. After that it clears itself. If a sleep request arrives while the bit is active, the block latches a "detector off" output. That output stays high until the wake input is asserted.

The register also holds an ordinary pull-up-disable bit, which is driven straight out to the port. The block has no other state. Reserved bits read back as zero.

Top module: `slp_ctl_reg`

## Requirements
- R1: Bits 7 and 3..0 of `rd_data` always read as zero.
- R2: Every write (`wr_en` high) stores `wr_data[4]` into the pull-up-disable bit. That bit reads back on `rd_data[4]` and drives `pud_out` from the next cycle on.
- R3: A write with `wr_data[6]=1` and `wr_data[5]=1` opens the unlock window. `rd_data[5]` reads 1 for exactly the four cycles after that write and reads 0 afterwards.
- R4: A write with `wr_data[6]=1` and `wr_data[5]=0` made while the window is open sets the protected bit. From the next cycle, `rd_data[6]` reads 1 and `rd_data[5]` reads 0, because the window closes.
- R5: Two kinds of write leave the protected bit unchanged and never open the window. The first is a step-two pattern (bit 6 at 1, bit 5 at 0) made while the window is closed. The second is a write with bit 5 at 1 and bit 6 at 0.
- R6: The protected bit counts as active from the third to the sixth clock edge after the edge that set it. It reads 1 from the setting edge until it clears itself at that sixth edge.
- R7: A sleep request sampled at an edge where the protected bit is active sets `det_off` at that edge. A request sampled at any other edge leaves `det_off` at 0.
- R8: Once `det_off` is high, it stays high until `wake` is sampled high. That edge clears it, and `wake` takes priority over a sleep request at the same edge.
- R9: After synchronous reset, `rd_data` is 0x00 and `det_off` and `pud_out` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Address-decoded write strobe for this register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| sleep_req | input | 1 | Sleep entry request from the sleep controller |
| wake | input | 1 | Wake event; releases `det_off` |
| det_off | output | 1 | Turn the brown-out detector off for this sleep |
| pud_out | output | 1 | Global pull-up disable |

## Verification
The checker enforces several rules on every cycle. Reserved bits read as zero. The pull-up bit follows the last write. A step-one write shows the enable bit on the next cycle. The protected bit can only rise right after a cycle in which the enable bit was visible. `det_off` rises only after a sleep request, holds until wake, and wake clears it. The exact length of the window, the three-cycle delay, the three-cycle active span, and the edge cycles where a sleep request is or is not accepted are counted only by the bench scenarios, which probe each of those boundaries.

// File: rtl/slp_ctl_pkg.sv
package slp_ctl_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_PROT = 6;
  localparam int BIT_EN   = 5;
  localparam int BIT_PUD  = 4;
endpackage

// File: rtl/slp_unlock_win.sv
module slp_unlock_win #(
  parameter int WIN_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic open_req,
  input  logic close_req,
  output logic win_open
);
  localparam int WW = $clog2(WIN_CYC + 1);
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (open_req)                cnt_q <= WW'(WIN_CYC);
    else if (close_req)               cnt_q <= '0;
    else if (cnt_q != '0)             cnt_q <= cnt_q - 1'b1;
  end

  assign win_open = (cnt_q != '0);
endmodule

// File: rtl/slp_prot_timer.sv
module slp_prot_timer #(
  parameter int SET_DLY = 3,
  parameter int ACT_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic is_set,
  output logic is_active
);
  localparam int TOT = SET_DLY + ACT_CYC;
  localparam int CW  = $clog2(TOT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start)         cnt_q <= CW'(TOT);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign is_set    = (cnt_q != '0);
  assign is_active = is_set && (cnt_q <= CW'(ACT_CYC));
endmodule

// File: rtl/slp_det_latch.sv
module slp_det_latch (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  input  logic armed,
  input  logic wake,
  output logic off_q
);
  always_ff @(posedge clk) begin
    if (rst)                     off_q <= 1'b0;
    else if (wake)               off_q <= 1'b0;
    else if (sleep_req && armed) off_q <= 1'b1;
  end
endmodule

// File: rtl/slp_ctl_reg.sv
module slp_ctl_reg
  import slp_ctl_pkg::*;
#(
  parameter int WIN_CYC = 4,
  parameter int SET_DLY = 3,
  parameter int ACT_CYC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             sleep_req,
  input  logic             wake,
  output logic             det_off,
  output logic             pud_out
);
  logic step_one, step_two, win_open, prot_set, prot_act, pud_q;

  assign step_one = wr_en &&  wr_data[BIT_PROT] &&  wr_data[BIT_EN];
  assign step_two = wr_en &&  wr_data[BIT_PROT] && !wr_data[BIT_EN];

  slp_unlock_win #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst(rst),
    .open_req(step_one), .close_req(step_two && win_open),
    .win_open(win_open)
  );

  slp_prot_timer #(.SET_DLY(SET_DLY), .ACT_CYC(ACT_CYC)) u_tmr (
    .clk(clk), .rst(rst),
    .start(step_two && win_open),
    .is_set(prot_set), .is_active(prot_act)
  );

  slp_det_latch u_lat (
    .clk(clk), .rst(rst),
    .sleep_req(sleep_req), .armed(prot_act), .wake(wake),
    .off_q(det_off)
  );

  always_ff @(posedge clk) begin
    if (rst)        pud_q <= 1'b0;
    else if (wr_en) pud_q <= wr_data[BIT_PUD];
  end

  assign pud_out = pud_q;

  always_comb begin
    rd_data           = '0;
    rd_data[BIT_PROT] = prot_set;
    rd_data[BIT_EN]   = win_open;
    rd_data[BIT_PUD]  = pud_q;
  end
endmodule

// File: rtl/slp_ctl_chk.sv
module slp_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       sleep_req,
  input logic       wake,
  input logic       det_off,
  input logic       pud_out
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_data[7] == 1'b0) && (rd_data[3:0] == 4'h0));

  p_pud_track_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (pud_out == $past(wr_data[4])) && (rd_data[4] == pud_out));

  p_win_open_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[6] && wr_data[5]) |=> rd_data[5]);

  p_set_needs_win_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[6]) |-> $past(rd_data[5]));

  p_off_needs_sleep_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(det_off) |-> $past(sleep_req) && $past(rd_data[6]));

  p_off_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (det_off && !wake) |=> det_off);

  p_wake_clr_r8: assert property (@(posedge clk) disable iff (rst)
    wake |=> !det_off);

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (rd_data == 8'h00) && !det_off && !pud_out);
endmodule

bind slp_ctl_reg slp_ctl_chk chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .sleep_req(sleep_req), .wake(wake),
  .det_off(det_off), .pud_out(pud_out)
);

// File: tb/slp_ctl_reg_tb_top.sv
module slp_ctl_reg_tb_top;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sleep_req = 1'b0;
  logic       wake = 1'b0;
  logic [7:0] rd_data;
  logic       det_off, pud_out;

  int n_tot = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic       off;
    logic       pud;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PER/2) clk = ~clk;

  slp_ctl_reg dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sleep_req(sleep_req), .wake(wake),
    .det_off(det_off), .pud_out(pud_out)
  );

  // monitor: compares the state after each edge against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_tot++;
        if (rd_data !== e.rd || det_off !== e.off || pud_out !== e.pud) begin
          n_bad++;
          $display("FAIL %s: rd=%02h off=%0b pud=%0b expected rd=%02h off=%0b pud=%0b",
                   e.tag, rd_data, det_off, pud_out, e.rd, e.off, e.pud);
        end
      end
    end
  end

  task automatic expect_now(input string tag, input logic [7:0] rd,
                            input logic off, input logic pud);
    exp_t e;
    e.tag = tag; e.rd = rd; e.off = off; e.pud = pud;
    sb_q.push_back(e);
  endtask

  // one clock: inputs applied after a falling edge, returns after the next one
  task automatic cyc(input logic we, input logic [7:0] d,
                     input logic slp, input logic wk);
    wr_en = we; wr_data = d; sleep_req = slp; wake = wk;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00; sleep_req = 1'b0; wake = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_now("R9 reset state", 8'h00, 1'b0, 1'b0);

    // R1/R2: reserved bits and pull-up bit
    cyc(1'b1, 8'h9F, 1'b0, 1'b0);
    expect_now("R1 reserved bits zero", 8'h10, 1'b0, 1'b1);
    cyc(1'b1, 8'h00, 1'b0, 1'b0);
    expect_now("R2 pud cleared", 8'h00, 1'b0, 1'b0);

    // R5: no unlock
    cyc(1'b1, 8'h40, 1'b0, 1'b0);
    expect_now("R5 set without unlock", 8'h00, 1'b0, 1'b0);
    cyc(1'b1, 8'h20, 1'b0, 1'b0);
    expect_now("R5 enable-only write", 8'h00, 1'b0, 1'b0);
    cyc(1'b1, 8'h40, 1'b0, 1'b0);
    expect_now("R5 set after enable-only", 8'h00, 1'b0, 1'b0);

    // R3: window length, R5: late step two
    cyc(1'b1, 8'h60, 1'b0, 1'b0);
    expect_now("R3 window open", 8'h20, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      idle(1);
      expect_now("R3 window still open", 8'h20, 1'b0, 1'b0);
    end
    idle(1);
    expect_now("R3 window closed", 8'h00, 1'b0, 1'b0);
    cyc(1'b1, 8'h40, 1'b0, 1'b0);
    expect_now("R5 late step two", 8'h00, 1'b0, 1'b0);

    // R4/R6: step two on last window cycle, self clear
    cyc(1'b1, 8'h70, 1'b0, 1'b0);
    expect_now("R2 pud with unlock", 8'h30, 1'b0, 1'b1);
    idle(3);
    cyc(1'b1, 8'h40, 1'b0, 1'b0);
    expect_now("R4 protected bit set", 8'h40, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      idle(1);
      expect_now("R6 bit still set", 8'h40, 1'b0, 1'b0);
    end
    idle(1);
    expect_now("R6 bit self-cleared", 8'h00, 1'b0, 1'b0);

    // R7: sleep too early, then at first active edge; R8 hold and wake
    cyc(1'b1, 8'h60, 1'b0, 1'b0);
    cyc(1'b1, 8'h40, 1'b0, 1'b0);
    idle(2);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    expect_now("R7 sleep before active", 8'h40, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    expect_now("R7 sleep while active", 8'h40, 1'b1, 1'b0);
    idle(2);
    expect_now("R8 off held after clear", 8'h00, 1'b1, 1'b0);
    idle(3);
    expect_now("R8 off still held", 8'h00, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    expect_now("R8 wake clears off", 8'h00, 1'b0, 1'b0);

    // R7: sleep at last active edge
    cyc(1'b1, 8'h60, 1'b0, 1'b0);
    cyc(1'b1, 8'h40, 1'b0, 1'b0);
    idle(5);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    expect_now("R7 sleep at last active edge", 8'h00, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b1);
    expect_now("R8 wake beats sleep", 8'h00, 1'b0, 1'b0);

    // R7: sleep after clear, R8: wake priority while active
    cyc(1'b1, 8'h60, 1'b0, 1'b0);
    cyc(1'b1, 8'h40, 1'b0, 1'b0);
    idle(6);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    expect_now("R7 sleep after clear", 8'h00, 1'b0, 1'b0);
    cyc(1'b1, 8'h60, 1'b0, 1'b0);
    cyc(1'b1, 8'h40, 1'b0, 1'b0);
    idle(3);
    cyc(1'b0, 8'h00, 1'b1, 1'b1);
    expect_now("R8 wake with sleep while active", 8'h40, 1'b0, 1'b0);

    // R9: reset mid-sequence
    cyc(1'b1, 8'h70, 1'b0, 1'b0);
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    expect_now("R9 reset clears all", 8'h00, 1'b0, 1'b0);

    idle(3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tot++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end
endmodule